// File: doc/BRIEF.md
# Load byte formatter

This block sits between a data cache and the register write port. It turns raw doublewords returned for a load into a value that can be written to a register. Loads may be 1, 2, 4 or 8 bytes long, may start at any byte address, and may be byte-reversed. The item can be sign-extended or zero-extended to the full width.

Every output lane has one wide multiplexer that picks any input lane. Rotation by the address offset and byte reversal therefore happen in a single selection step.

When a load crosses a doubleword boundary, the requester presents two beats. The block rotates the first beat, keeps it in a holding register, and splices it with the rotated second beat. It then trims the result to the access length and extends it.

With the result it can also produce a less-than / greater-than / equal-to-zero indication, used to set a condition field. In narrow mode this test looks only at the low 32 bits.

Top module: `ldfmt_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0, `out_data` is all zeros and `out_cr` is 000.
- R2: A single-beat load, accepted when `in_valid` is 1, gives `out_valid`=1 on the next cycle.
  - Lane k is bits 8k+7:8k.
  - `in_len` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
  - Byte m of the result is the input byte at lane `in_addr`+m.
- R3: With `in_rev`=1, the byte order of the loaded item is reversed. Byte m of the result is memory byte n-1-m of the item, where n is the length in bytes.
- R4: With `in_sext`=0, every result byte at position n or above is zero.
- R5: With `in_sext`=1, the bytes at position n and above are copies of bit 8n-1 of the item, taken after any reversal.
- R6: A beat with `in_span`=1 and no beat pending is held back, and no output is produced for it.
  - For the next beat, item bytes whose memory offset (addr+m) is 8 or more come from lane offset-8 of that second beat. All other item bytes come from the first beat.
  - All attribute inputs (address, length, reverse, extend, span, record, narrow mode) given with the second beat are ignored. The first beat's attributes are used.
- R7: Any number of cycles with `in_valid`=0 may pass between the two beats of a split load. The result appears, with `out_valid`=1, exactly one cycle after the second beat.
- R8: `out_cr` is {lt, gt, eq}.
  - When the record flag was 1: eq=1 if the result is zero; lt=1 if its top bit is 1; otherwise gt=1.
  - When the record flag was 0, or `out_valid` is 0, `out_cr` is 000.
- R9: With narrow mode (`in_m32`=1), the zero test and the sign test for `out_cr` use only bits 31:0 of the result.
- R10: `out_valid` is 1 only in the cycle after a beat that completes a load. Cycles with `in_valid`=0 produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A cache doubleword is present |
| in_data | input | 64 | Doubleword from the cache |
| in_addr | input | 3 | Low address bits of the access |
| in_len | input | 2 | Length code (0:1, 1:2, 2:4, 3:8 bytes) |
| in_rev | input | 1 | Byte-reversed load |
| in_sext | input | 1 | Sign-extend the item |
| in_span | input | 1 | Access crosses into the next doubleword |
| in_rc | input | 1 | Produce the condition indication |
| in_m32 | input | 1 | Narrow mode: condition test on low 32 bits |
| out_valid | output | 1 | Formatted result is present |
| out_data | output | 64 | Formatted, extended result |
| out_cr | output | 3 | {lt, gt, eq} of the result, or 000 |

## Verification
The bench sweeps every start offset, every length and all combinations of the reverse and extend flags over varied data. This catches two kinds of error:
- A lane select that shifts instead of rotating, or reverses about the wrong pivot, gives misplaced bytes.
- Taking the sign from the unreversed item's top byte gives wrong fill bytes.

For split loads, the second beat carries conflicting attributes and arrives after varying idle gaps. A design that reads attributes from the second beat produces a wrongly shaped result. A design that emits on the first beat produces an early strobe.

Condition cases use data that is zero only in its low word, or negative only at bit 31. A design that ignores narrow mode reports the wrong relation to zero.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } crf_t;

  function automatic crf_t crf_make(input logic neg, input logic zero);
    crf_t r;
    r.lt = neg;
    r.eq = zero;
    r.gt = !neg && !zero;
    return r;
  endfunction

endpackage

// File: rtl/ldfmt_lane_ctl.sv
module ldfmt_lane_ctl #(
  parameter int LANES = 8,
  parameter int AW    = $clog2(LANES)
) (
  input  logic [AW-1:0]       shift,
  input  logic [AW:0]         cnt,
  input  logic                rev,
  output logic [LANES*AW-1:0] sel,
  output logic [LANES-1:0]    second,
  output logic [LANES-1:0]    keep
);

  localparam logic [AW+1:0] ONE = (AW+2)'(1);
  localparam logic [AW+1:0] LIM = (AW+2)'(LANES);

  logic [AW+1:0] base;
  logic [AW+1:0] wide_cnt;
  assign base     = {2'b00, shift};
  assign wide_cnt = {1'b0, cnt};

  // Memory offset of each result byte decides both the lane and the beat.
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [AW+1:0] J = (AW+2)'(j);
    logic [AW+1:0] off;
    assign off = rev ? (base + wide_cnt - ONE - J) : (base + J);
    assign sel[j*AW +: AW] = off[AW-1:0];
    assign second[j]       = (off >= LIM);
    assign keep[j]         = (J < wide_cnt);
  end

endmodule

// File: rtl/ldfmt_xbar.sv
module ldfmt_xbar #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  parameter int AW     = $clog2(LANES)
) (
  input  logic [LANES*BYTE_W-1:0] din,
  input  logic [LANES*AW-1:0]     sel,
  output logic [LANES*BYTE_W-1:0] dout
);

  // One any-to-any selector per output lane: rotation and reversal together.
  for (genvar j = 0; j < LANES; j++) begin : g_mux
    logic [AW-1:0] s;
    assign s = sel[j*AW +: AW];
    assign dout[j*BYTE_W +: BYTE_W] = din[s*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/ldfmt_ext.sv
module ldfmt_ext #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  parameter int AW     = $clog2(LANES)
) (
  input  logic [LANES*BYTE_W-1:0] din,
  input  logic [LANES-1:0]        keep,
  input  logic [AW:0]             cnt,
  input  logic                    sext,
  output logic [LANES*BYTE_W-1:0] dout
);

  logic sgn;

  // Sign comes from the top byte of the item after reversal.
  always_comb begin
    sgn = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (j + 1 == int'(cnt)) sgn = din[j*BYTE_W + BYTE_W - 1];
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_fill
    assign dout[j*BYTE_W +: BYTE_W] = keep[j] ? din[j*BYTE_W +: BYTE_W]
                                              : {BYTE_W{sext & sgn}};
  end

endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  parameter int DW     = LANES * BYTE_W,
  parameter int AW     = $clog2(LANES),
  parameter int LEN_W  = $clog2(AW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic [AW-1:0]    in_addr,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_rev,
  input  logic             in_sext,
  input  logic             in_span,
  input  logic             in_rc,
  input  logic             in_m32,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [2:0]       out_cr
);
  import ldfmt_pkg::*;

  // Holding state for the first beat of a split load.
  logic             pend_q;
  logic [DW-1:0]    hold_q;
  logic [AW-1:0]    a_addr_q;
  logic [LEN_W-1:0] a_len_q;
  logic             a_rev_q, a_sext_q, a_rc_q, a_m32_q;

  // Effective attributes: the latched ones win while a beat is pending.
  logic [AW-1:0]    e_addr;
  logic [LEN_W-1:0] e_len;
  logic             e_rev, e_sext, e_rc, e_m32;
  assign e_addr = pend_q ? a_addr_q : in_addr;
  assign e_len  = pend_q ? a_len_q  : in_len;
  assign e_rev  = pend_q ? a_rev_q  : in_rev;
  assign e_sext = pend_q ? a_sext_q : in_sext;
  assign e_rc   = pend_q ? a_rc_q   : in_rc;
  assign e_m32  = pend_q ? a_m32_q  : in_m32;

  logic [AW:0] cnt;
  assign cnt = (AW+1)'(1) << e_len;

  logic [LANES*AW-1:0] sel;
  logic [LANES-1:0]    second, keep;
  logic [DW-1:0]       rot, merged, ext;

  ldfmt_lane_ctl #(.LANES(LANES), .AW(AW)) u_ctl (
    .shift(e_addr), .cnt(cnt), .rev(e_rev),
    .sel(sel), .second(second), .keep(keep)
  );

  ldfmt_xbar #(.LANES(LANES), .BYTE_W(BYTE_W), .AW(AW)) u_xbar (
    .din(in_data), .sel(sel), .dout(rot)
  );

  // Splice: lanes whose bytes live in the first doubleword come from the hold.
  for (genvar j = 0; j < LANES; j++) begin : g_merge
    assign merged[j*BYTE_W +: BYTE_W] = (pend_q && !second[j])
                                        ? hold_q[j*BYTE_W +: BYTE_W]
                                        : rot[j*BYTE_W +: BYTE_W];
  end

  ldfmt_ext #(.LANES(LANES), .BYTE_W(BYTE_W), .AW(AW)) u_ext (
    .din(merged), .keep(keep), .cnt(cnt), .sext(e_sext), .dout(ext)
  );

  logic t_neg, t_zero;
  crf_t cr_n;
  assign t_neg  = e_m32 ? ext[31] : ext[DW-1];
  assign t_zero = e_m32 ? (ext[31:0] == 32'd0) : (ext == '0);
  assign cr_n   = crf_make(t_neg, t_zero);

  logic first_beat;
  assign first_beat = in_valid && !pend_q && in_span;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      hold_q    <= '0;
      a_addr_q  <= '0;
      a_len_q   <= '0;
      a_rev_q   <= 1'b0;
      a_sext_q  <= 1'b0;
      a_rc_q    <= 1'b0;
      a_m32_q   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_cr    <= 3'b000;
    end else begin
      out_valid <= 1'b0;
      out_cr    <= 3'b000;
      if (first_beat) begin
        pend_q   <= 1'b1;
        hold_q   <= rot;
        a_addr_q <= in_addr;
        a_len_q  <= in_len;
        a_rev_q  <= in_rev;
        a_sext_q <= in_sext;
        a_rc_q   <= in_rc;
        a_m32_q  <= in_m32;
      end else if (in_valid) begin
        pend_q    <= 1'b0;
        out_valid <= 1'b1;
        out_data  <= ext;
        out_cr    <= e_rc ? cr_n : 3'b000;
      end
    end
  end

  // R6
  first_beat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    first_beat |=> !out_valid);

  // R7
  wait_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !in_valid) |=> (pend_q && !out_valid));

  // R10
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R8
  cr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_cr == 3'b000));

  // R8
  cr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_cr));

endmodule

// File: tb/ldfmt_top_tb_top.sv
module ldfmt_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [2:0]  in_addr = '0;
  logic [1:0]  in_len = '0;
  logic        in_rev = 1'b0, in_sext = 1'b0, in_span = 1'b0;
  logic        in_rc = 1'b0, in_m32 = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [2:0]  out_cr;

  int checks = 0;
  int errors = 0;

  logic        exp_v = 1'b0;
  logic [63:0] exp_d = '0;
  logic [2:0]  exp_cr = '0;
  string       tag = "R1";

  always #2 clk = ~clk;

  ldfmt_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_addr(in_addr), .in_len(in_len), .in_rev(in_rev), .in_sext(in_sext),
    .in_span(in_span), .in_rc(in_rc), .in_m32(in_m32),
    .out_valid(out_valid), .out_data(out_data), .out_cr(out_cr)
  );

  function automatic logic [63:0] ref_value(logic [127:0] w, int s, int n,
                                            bit rev, bit sx);
    logic [63:0] v = '0;
    for (int m = 0; m < n; m++) begin
      int src = rev ? (n - 1 - m) : m;
      v[m*8 +: 8] = w[(s + src)*8 +: 8];
    end
    if (sx && v[n*8-1])
      for (int m = n; m < 8; m++) v[m*8 +: 8] = 8'hFF;
    return v;
  endfunction

  function automatic logic [2:0] ref_cr(logic [63:0] v, bit rc, bit m32);
    bit neg, zero;
    if (!rc) return 3'b000;
    neg  = m32 ? v[31] : v[63];
    zero = m32 ? (v[31:0] == 0) : (v == 0);
    return {neg, !neg && !zero, zero};
  endfunction

  // One clock: DUT captures at posedge, outputs compared at the following negedge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== exp_v ||
        (exp_v && out_data !== exp_d) || out_cr !== exp_cr) begin
      errors++;
      $display("FAIL %s: valid=%b data=%h cr=%b expected valid=%b data=%h cr=%b",
               tag, out_valid, out_data, out_cr, exp_v, exp_d, exp_cr);
    end
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) begin
      in_valid = 1'b0;
      in_data  = 64'hDEAD_BEEF_0BAD_F00D;
      exp_v = 1'b0; exp_cr = 3'b000;
      tick();
    end
  endtask

  task automatic do_load(logic [127:0] w, int s, int len, bit rev, bit sx,
                         bit rc, bit m32, int gap);
    int n = 1 << len;
    bit span = (s + n) > 8;
    logic [63:0] v = ref_value(w, s, n, rev, sx);
    in_valid = 1'b1; in_data = w[63:0];
    in_addr = 3'(s); in_len = 2'(len);
    in_rev = rev; in_sext = sx; in_span = span; in_rc = rc; in_m32 = m32;
    if (span) begin
      exp_v = 1'b0; exp_cr = 3'b000;
      tick();
      idle(gap);
      // R6: conflicting attributes on the second beat must be ignored.
      in_valid = 1'b1; in_data = w[127:64];
      in_addr = ~3'(s); in_len = ~2'(len);
      in_rev = ~rev; in_sext = ~sx; in_span = 1'b1; in_rc = ~rc; in_m32 = ~m32;
    end
    exp_v = 1'b1; exp_d = v; exp_cr = ref_cr(v, rc, m32);
    tick();
    in_valid = 1'b0; in_span = 1'b0;
    exp_v = 1'b0; exp_cr = 3'b000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] w;
    // R1
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 64'd0 || out_cr !== 3'b000) begin
      errors++;
      $display("FAIL R1: valid=%b data=%h cr=%b expected 0/0/000",
               out_valid, out_data, out_cr);
    end
    rst = 1'b0;
    idle(2);

    w = 128'h1F1E1D1C1B1A1918_8786858483828180;
    // R2: aligned and in-word offsets, all lengths
    tag = "R2";
    do_load(w, 0, 3, 0, 0, 0, 0, 0);
    do_load(w, 4, 2, 0, 0, 0, 0, 0);
    do_load(w, 3, 0, 0, 0, 0, 0, 0);
    do_load(w, 6, 1, 0, 0, 0, 0, 0);
    // R3: byte reversal
    tag = "R3";
    do_load(w, 0, 3, 1, 0, 0, 0, 0);
    do_load(w, 2, 1, 1, 0, 0, 0, 0);
    // R4: zero extension of a negative-looking item
    tag = "R4";
    do_load(w, 4, 1, 0, 0, 0, 0, 0);
    // R5: sign from the item top byte after reversal
    tag = "R5";
    do_load(w, 0, 1, 0, 1, 0, 0, 0);
    do_load(128'h00000000_00000000_00000000_00007F80, 0, 1, 1, 1, 0, 0, 0);
    do_load(128'h00000000_00000000_00000000_00007F80, 0, 1, 0, 1, 0, 0, 0);
    // R6: split loads, R7: with idle gaps between beats
    tag = "R6";
    do_load(w, 5, 2, 0, 0, 0, 0, 0);
    do_load(w, 7, 3, 1, 1, 1, 0, 0);
    tag = "R7";
    do_load(w, 6, 2, 1, 1, 1, 0, 3);
    do_load(w, 1, 3, 0, 0, 1, 1, 5);
    // R8: record indication for zero, negative, positive, and off
    tag = "R8";
    do_load(128'd0, 0, 3, 0, 0, 1, 0, 0);
    do_load(w, 0, 3, 0, 0, 1, 0, 0);
    do_load(w, 0, 2, 0, 0, 1, 0, 0);
    do_load(w, 0, 3, 0, 0, 0, 0, 0);
    // R9: narrow mode uses only the low word
    tag = "R9";
    do_load(128'h0_0000_0000_FFFF_0000_0000_0000, 0, 3, 0, 0, 1, 1, 0);
    do_load(128'h0_0000_0000_0000_0000_8000_0000, 0, 3, 0, 0, 1, 1, 0);
    do_load(128'h0_0000_0000_0000_0000_8000_0000, 0, 3, 0, 0, 1, 0, 0);
    // R10: no output while idle
    tag = "R10";
    idle(4);

    // Full sweep of offset, length, reverse and extend
    for (int s = 0; s < 8; s++)
      for (int len = 0; len < 4; len++)
        for (int f = 0; f < 4; f++) begin
          w = {$urandom, $urandom, $urandom, $urandom};
          tag = ((s + (1 << len)) > 8) ? "R6" : "R2";
          do_load(w, s, len, f[0], f[1], 1'b1, (s + len) % 2 == 1, s % 3);
        end
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule